// File: doc/BRIEF.md
# Dual Byte FIFO with Interrupt Causes

This block holds two byte queues of 64 entries each between a word-wide register port and a serial-bus sequencer. Software loads transmit bytes through a register write and drains received bytes through a register read. The sequencer takes transmit bytes and delivers received bytes over two valid/ready streams. Each queue has its own enable bit and its own programmable trigger level. A status word reports both fill levels, along with full and empty flags.

Ten interrupt cause bits latch level-trigger conditions, overflow and underflow on either side, a trailing-data timeout and an external bus-event pulse. The cause bits are cleared by writing 1 to them. An enable word masks them onto a single interrupt line. The trailing timer raises a cause when received bytes have sat below the receive trigger for a programmed number of divided-clock ticks. This way a short final burst is still reported.

Back-pressure rules: `tx_valid` is high whenever the transmit queue holds a byte, and a byte leaves on a cycle with `tx_valid` and `tx_ready` both high. `tx_data` stays unchanged while it waits. `rx_ready` is high only while the receive queue is enabled and not full, and a byte is accepted on a cycle with `rx_valid` and `rx_ready` both high.

Top module: `dual_byte_fifo_irq`

Register word addresses: 0 queue control, 1 trailing limit, 2 interrupt enable, 3 interrupt status, 4 queue status, 5 transmit data (write), 6 receive data (read). `reg_rdata` shows the addressed word combinationally.

## Requirements
- R1: After reset, control reads 0, trailing limit reads 15, interrupt status and enable read 0, queue status reads 0x01000100 (both empty), `irq` is low, `tx_valid` is low and `rx_ready` is low.
- R2: Each queue is first-in first-out with 64 entries. Queue status bits: transmit level [6:0], transmit full bit 7, transmit empty bit 8, receive level [22:16], receive full bit 23, receive empty bit 24.
- R3: A transmit-data write to a full transmit queue is dropped, leaves the stored bytes intact and sets cause bit 3.
- R4: A receive-data read from an empty, enabled receive queue returns 0 and sets cause bit 4.
- R5: The sequencer receives transmit bytes in write order. `tx_ready` high while the enabled transmit queue is empty sets cause bit 2, and `tx_valid` is then low.
- R6: `rx_ready` is low while the receive queue is full. `rx_valid` on a full, enabled receive queue drops the byte and sets cause bit 5.
- R7: Control bit 0 enables receive and bit 1 enables transmit. The receive trigger sits at bits [10:4] and the transmit trigger at bits [22:16]. Cause bit 0 is set while the enabled transmit level is at or below its trigger. Cause bit 1 is set while the enabled receive level is at or above its trigger.
- R8: While the receive queue is non-empty and below its trigger, cause bit 6 is set once the queue has gone the trailing-limit number of ticks (each `TICK_DIV` clocks) without a new byte. It fires once per idle period. Any accepted receive byte restarts the count.
- R9: A one-cycle `i2c_event` pulse sets cause bit 9.
- R10: Writing 1 to a status bit clears it. Writing back the value just read clears every latched cause. A cause raised in the same cycle as its clear stays set.
- R11: `irq` is the OR of the status bits ANDed with the enable bits.
- R12: A disabled queue reads as empty. Pushes to it are dropped and raise no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| tx_valid | output | 1 | Transmit byte available to sequencer |
| tx_ready | input | 1 | Sequencer takes transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Sequencer offers a received byte |
| rx_ready | output | 1 | Receive queue can accept |
| rx_data | input | 8 | Received byte |
| i2c_event | input | 1 | Bus-event pulse from sequencer |
| irq | output | 1 | Masked interrupt |

## Verification
A vector table runs a short mixed stream: three bytes out and two bytes in. Level reads in between separate correct level counting from off-by-one pointer updates, and they show the trigger comparisons flip at the programmed thresholds. Directed runs fill each queue to exactly 64 and push one more byte. This tells a dropped overflow apart from an overwrite of the oldest byte, and full-drain ordering exposes wrap faults. The trailing test reads status well before and well after the programmed timeout and again after a clear, which separates a correct one-shot timer from one that never fires or refires. A clear issued in the same cycle as a new bus event shows whether set takes priority over clear.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;
  localparam int NCAUSE = 10;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_TRAIL = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_ISTAT = 3'd3;
  localparam logic [2:0] A_FSTAT = 3'd4;
  localparam logic [2:0] A_TXD   = 3'd5;
  localparam logic [2:0] A_RXD   = 3'd6;

  localparam int C_TXAE  = 0;
  localparam int C_RXAF  = 1;
  localparam int C_TXUR  = 2;
  localparam int C_TXOR  = 3;
  localparam int C_RXUR  = 4;
  localparam int C_RXOR  = 5;
  localparam int C_TRAIL = 6;
  localparam int C_EVT   = 9;
endpackage

// File: rtl/dbf_fifo.sv
`timescale 1ns/1ps
module dbf_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = cnt;
  assign rdata   = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dbf_trail_timer.sv
`timescale 1ns/1ps
module dbf_trail_timer #(
  parameter int TICK_DIV = 4,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          active,
  input  logic          below,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre;
  logic [CW-1:0] tcnt;
  logic          fired;
  logic          tick;

  assign tick = (pre == PW'(TICK_DIV - 1));
  assign fire = active && !restart && !fired && below && (tcnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      tcnt  <= '0;
      fired <= 1'b0;
    end else if (restart) begin
      pre   <= '0;
      tcnt  <= '0;
      fired <= 1'b0;
    end else begin
      if (fire) fired <= 1'b1;
      if (tick) begin
        pre <= '0;
        if (tcnt != {CW{1'b1}}) tcnt <= tcnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbf_irq_ctrl.sv
`timescale 1ns/1ps
module dbf_irq_ctrl #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cause,
  input  logic         ien_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;
  assign irq      = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_mask) | cause;
      if (ien_we) enable <= wdata;
    end
  end
endmodule

// File: rtl/dual_byte_fifo_irq.sv
`timescale 1ns/1ps
module dual_byte_fifo_irq
  import dbf_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int TICK_DIV = 4,
  parameter int TRAIL_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        i2c_event,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic               rx_en, tx_en;
  logic [LW-1:0]      rx_trig, tx_trig;
  logic [TRAIL_W-1:0] trail_lim;

  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]    rx_head;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic          trail_fire;
  logic [NCAUSE-1:0] cause, istat, ien;

  wire unused_wdata = ^reg_wdata[31:23];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en     <= 1'b0;
      tx_en     <= 1'b0;
      rx_trig   <= '0;
      tx_trig   <= '0;
      trail_lim <= {TRAIL_W{1'b1}};
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        rx_en   <= reg_wdata[0];
        tx_en   <= reg_wdata[1];
        rx_trig <= reg_wdata[4 +: LW];
        tx_trig <= reg_wdata[16 +: LW];
      end
      if (reg_addr == A_TRAIL) trail_lim <= reg_wdata[TRAIL_W-1:0];
    end
  end

  assign tx_push  = reg_wr && (reg_addr == A_TXD) && tx_en;
  assign tx_valid = !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign rx_ready = rx_en && !rx_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = reg_rd && (reg_addr == A_RXD) && rx_en;

  dbf_fifo #(.DEPTH(DEPTH), .DW(8), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .push(tx_push), .wdata(reg_wdata[7:0]), .pop(tx_pop), .rdata(tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  dbf_fifo #(.DEPTH(DEPTH), .DW(8), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en),
    .push(rx_push), .wdata(rx_data), .pop(rx_pop), .rdata(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  dbf_trail_timer #(.TICK_DIV(TICK_DIV), .CW(TRAIL_W)) u_trail (
    .clk(clk), .rst_n(rst_n),
    .restart(rx_push || rx_empty), .active(!rx_empty),
    .below(rx_lvl < rx_trig), .limit(trail_lim), .fire(trail_fire)
  );

  always_comb begin
    cause          = '0;
    cause[C_TXAE]  = tx_en && (tx_lvl <= tx_trig);
    cause[C_RXAF]  = rx_en && (rx_lvl >= rx_trig);
    cause[C_TXUR]  = tx_en && tx_ready && tx_empty;
    cause[C_TXOR]  = tx_push && tx_full;
    cause[C_RXUR]  = rx_pop && rx_empty;
    cause[C_RXOR]  = rx_en && rx_valid && rx_full;
    cause[C_TRAIL] = trail_fire;
    cause[C_EVT]   = i2c_event;
  end

  dbf_irq_ctrl #(.N(NCAUSE)) u_irq (
    .clk(clk), .rst_n(rst_n), .cause(cause),
    .ien_we(reg_wr && (reg_addr == A_IEN)),
    .clr_we(reg_wr && (reg_addr == A_ISTAT)),
    .wdata(reg_wdata[NCAUSE-1:0]),
    .status(istat), .enable(ien), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]        = rx_en;
        reg_rdata[1]        = tx_en;
        reg_rdata[4 +: LW]  = rx_trig;
        reg_rdata[16 +: LW] = tx_trig;
      end
      A_TRAIL: reg_rdata[TRAIL_W-1:0] = trail_lim;
      A_IEN:   reg_rdata[NCAUSE-1:0]  = ien;
      A_ISTAT: reg_rdata[NCAUSE-1:0]  = istat;
      A_FSTAT: begin
        reg_rdata[0 +: LW]  = tx_lvl;
        reg_rdata[7]        = tx_full;
        reg_rdata[8]        = tx_empty;
        reg_rdata[16 +: LW] = rx_lvl;
        reg_rdata[23]       = rx_full;
        reg_rdata[24]       = rx_empty;
      end
      A_RXD:   reg_rdata[7:0] = rx_head;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbf_chk.sv
`timescale 1ns/1ps
module dbf_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_en,
  input logic          tx_full,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic          i2c_event,
  input logic [9:0]    istat,
  input logic [9:0]    ien,
  input logic          irq
);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && tx_en) |=> (!tx_en || (tx_valid && $stable(tx_data))));

  // R3
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5 && tx_en && tx_full && !tx_ready)
      |=> (istat[3] && tx_lvl == LW'(DEPTH)));

  // R2
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  // R9
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_event |=> istat[9]);

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[9] && !i2c_event) |=> !istat[9]);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

bind dual_byte_fifo_irq dbf_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_en(tx_en), .tx_full(tx_full), .tx_lvl(tx_lvl),
  .rx_lvl(rx_lvl), .i2c_event(i2c_event), .istat(istat), .ien(ien), .irq(irq)
);

// File: tb/sim_dual_byte_fifo_irq.sv
`timescale 1ns/1ps
module sim_dual_byte_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        i2c_event = 1'b0;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_byte_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .i2c_event(i2c_event), .irq(irq)
  );

  // op: 0 write, 1 read+compare, 2 sequencer push, 3 sequencer take+compare
  // fields: {op[1:0], addr[2:0], data[31:0], expect[31:0]}
  localparam int NV = 19;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 3'd0, 32'h0001_0023, 32'h0},
    {2'd0, 3'd5, 32'h0000_00A1, 32'h0},
    {2'd0, 3'd5, 32'h0000_00B2, 32'h0},
    {2'd0, 3'd5, 32'h0000_00C3, 32'h0},
    {2'd1, 3'd4, 32'h0,         32'h0100_0003},
    {2'd1, 3'd3, 32'h0,         32'h0000_0001},
    {2'd0, 3'd3, 32'h0000_0001, 32'h0},
    {2'd1, 3'd3, 32'h0,         32'h0000_0000},
    {2'd3, 3'd0, 32'h0,         32'h0000_00A1},
    {2'd3, 3'd0, 32'h0,         32'h0000_00B2},
    {2'd1, 3'd3, 32'h0,         32'h0000_0001},
    {2'd2, 3'd0, 32'h0000_005C, 32'h0},
    {2'd2, 3'd0, 32'h0000_006D, 32'h0},
    {2'd1, 3'd4, 32'h0,         32'h0002_0001},
    {2'd1, 3'd3, 32'h0,         32'h0000_0003},
    {2'd1, 3'd6, 32'h0,         32'h0000_005C},
    {2'd1, 3'd6, 32'h0,         32'h0000_006D},
    {2'd3, 3'd0, 32'h0,         32'h0000_00C3},
    {2'd1, 3'd4, 32'h0,         32'h0100_0100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] q);
    reg_rd = 1'b1; reg_addr = a;
    #1 q = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, output logic rdy);
    rx_valid = 1'b1; rx_data = d;
    #1 rdy = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic take(output logic v, output logic [7:0] q);
    tx_ready = 1'b1;
    #1 begin v = tx_valid; q = tx_data; end
    @(negedge clk);
    tx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] q;
    logic        v, r;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, q); check("R1 ctrl", q, 32'h0);
    rd(3'd1, q); check("R1 trail", q, 32'hF);
    rd(3'd2, q); check("R1 ien", q, 32'h0);
    rd(3'd3, q); check("R1 istat", q, 32'h0);
    rd(3'd4, q); check("R1 fstat", q, 32'h0100_0100);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h0);

    // R12 disabled queues drop pushes, no causes
    wr(3'd5, 32'h55);
    push(8'h66, r);
    rd(3'd4, q); check("R12 fstat", q, 32'h0100_0100);
    rd(3'd3, q); check("R12 istat", q, 32'h0);

    // table walk (R2, R7, R10 mixed traffic)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][68:67])
        2'd0: wr(VEC[i][66:64], VEC[i][63:32]);
        2'd1: begin
          rd(VEC[i][66:64], q);
          check($sformatf("R2/R7 table %0d", i), q, VEC[i][31:0]);
        end
        2'd2: push(VEC[i][39:32], r);
        default: begin
          take(v, b);
          check($sformatf("R5 table %0d", i), {23'b0, v, b}, {23'b0, 1'b1, VEC[i][7:0]});
        end
      endcase
    end

    // R2 and R3: fill transmit queue, overflow, drain in order, underrun (R5)
    wr(3'd0, 32'h0000_0002);
    wr(3'd3, 32'h3FF);
    for (int i = 0; i < 64; i++) wr(3'd5, 32'(8'h10 + i));
    rd(3'd4, q); check("R2 tx full status", q, 32'h0100_00C0);
    wr(3'd5, 32'hEE);
    rd(3'd3, q); check("R3 overrun bit", q & 32'h8, 32'h8);
    rd(3'd4, q); check("R3 level kept", q, 32'h0100_00C0);
    for (int i = 0; i < 64; i++) begin
      take(v, b);
      if (i == 0 || i == 63 || b !== 8'(8'h10 + i))
        check("R2 tx order", {23'b0, v, b}, {23'b0, 1'b1, 8'(8'h10 + i)});
    end
    take(v, b);
    check("R5 tx_valid empty", {31'b0, v}, 32'h0);
    rd(3'd3, q); check("R5 underrun bit", q & 32'h4, 32'h4);

    // R4 empty receive read
    wr(3'd0, 32'h0000_0001);
    rd(3'd6, q); check("R4 empty read", q, 32'h0);
    rd(3'd3, q); check("R4 underrun bit", q & 32'h10, 32'h10);

    // R6 fill receive queue and overflow
    wr(3'd0, 32'h0000_0401);
    for (int i = 0; i < 64; i++) push(8'(8'h80 + i), r);
    push(8'hFF, r);
    check("R6 rx_ready full", {31'b0, r}, 32'h0);
    rd(3'd3, q); check("R6 overrun bit", q & 32'h20, 32'h20);
    rd(3'd4, q); check("R6 rx full status", q, 32'h00C0_0100);
    for (int i = 0; i < 64; i++) begin
      rd(3'd6, q);
      if (i == 0 || i == 63 || q !== 32'(8'h80 + i))
        check("R6 rx order", q, 32'(8'h80 + i));
    end
    rd(3'd4, q); check("R6 rx drained", q, 32'h0100_0100);

    // R8 trailing timeout, R11 irq masking
    wr(3'd0, 32'h0000_0081);
    wr(3'd1, 32'h3);
    wr(3'd3, 32'h3FF);
    rd(3'd3, q); check("R10 clear all", q, 32'h0);
    push(8'h3C, r);
    rd(3'd3, q); check("R8 not yet", q, 32'h0);
    repeat (20) @(negedge clk);
    rd(3'd3, q); check("R8 trailing fired", q, 32'h40);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h40);
    check("R11 irq enabled", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h0);
    check("R11 irq disabled", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h40);
    repeat (20) @(negedge clk);
    rd(3'd3, q); check("R8 fires once", q, 32'h0);
    rd(3'd6, q); check("R8 byte kept", q, 32'h3C);

    // R9 event, R10 write-back clear and set priority
    i2c_event = 1'b1; @(negedge clk); i2c_event = 1'b0; @(negedge clk);
    rd(3'd3, q); check("R9 event bit", q, 32'h200);
    wr(3'd3, q);
    rd(3'd3, q); check("R10 write-back", q, 32'h0);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h200; i2c_event = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; i2c_event = 1'b0;
    @(negedge clk);
    rd(3'd3, q); check("R10 set wins", q, 32'h200);
    wr(3'd2, 32'h200);
    check("R11 irq event", {31'b0, irq}, 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule